// File: doc/BRIEF.md
# Delay-Slot Macro Sequencer

This block is the control core of a small macro processor. A start pulse hands it a start address, a parameter count and the first parameter. It then fetches one 32-bit instruction per cycle from a word-addressed macro memory, starting at that address. It keeps eight 32-bit registers, with register 0 fixed at zero, and it steers the program counter through conditional branches and exits. Both branches and exits can run one trailing instruction in a delay slot.

Arithmetic, bitfield and output-dispatch logic sit outside the block. For each instruction the sequencer presents the opcode, the result mode, both source operand values and the sum of source A with the sign-extended immediate. It takes back a result word for the register write. Remaining parameters arrive on a stream that the sequencer draws from whenever the result mode consumes one. At the end it raises a one-cycle completion pulse with two flags: one reports an illegal instruction, the other reports that the parameter count was not matched.

Top module: `macro_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `illegalErr`, `paramErr` and `paramTake` are low.
- R2: A `start` pulse while idle clears all registers, loads `firstParam` into register 1 and sets the parameter index to 1. In the next cycle `busy` is high and `instrAddr` equals `startOffset`. One instruction executes per busy cycle.
- R3: Register 0 reads as zero, and writes that target it are dropped.
- R4: Instruction fields: opcode bits 2:0, result mode bits 6:4, destination bits 10:8, source A bits 13:11 and source B bits 16:14. Every non-branch, legal instruction writes its destination. Result modes 0, 3 and 5 write `paramData`; all other modes write `execResult`. Modes 0, 3, 5 and 6 raise `paramTake` for one cycle, which advances the parameter stream.
- R5: Opcode 7 is a branch with no register write. Bit 4 selects the test on source A: 0 means branch if zero, 1 means branch if non-zero. The target is the branch's own address plus the signed 18-bit immediate in bits 31:14. A branch that is not taken falls through to the next address.
- R6: When a taken branch has bit 5 clear, the next sequential instruction runs as a delay slot, then execution continues at the target.
- R7: When a taken branch has bit 5 set, execution continues at the target in the next cycle, with no delay slot.
- R8: Exit bit 7 on an instruction outside a delay slot makes one more sequential instruction run, then the sequencer halts. The exit bit is ignored inside a delay slot and on a taken branch.
- R9: Opcode 6, or a branch inside a delay slot, is illegal. It writes nothing, takes no parameter and halts the sequencer with `illegalErr` set during the `done` pulse.
- R10: `done` is high for exactly one cycle, in the cycle after the last busy cycle. `paramErr` is high with it when the number of parameters consumed, counting the first, differs from `paramCount`.
- R11: A `start` pulse while busy is ignored.
- R12: `aImmSum` equals `srcAVal` plus the sign-extended immediate of the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution (accepted while idle) |
| startOffset | input | ADDR_W | Address of the first instruction |
| paramCount | input | CNT_W | Number of parameters supplied, including the first |
| firstParam | input | 32 | First parameter, loaded into register 1 |
| instrAddr | output | ADDR_W | Macro memory word address |
| instrData | input | 32 | Instruction word at `instrAddr` (same cycle) |
| paramData | input | 32 | Head of the parameter stream |
| paramTake | output | 1 | Consume the head of the parameter stream |
| execResult | input | 32 | Result from the external datapath for the current instruction |
| busy | output | 1 | An instruction executes this cycle |
| opCode | output | 3 | Opcode of the current instruction |
| resMode | output | 3 | Result mode of the current instruction |
| srcAVal | output | 32 | Value of source register A |
| srcBVal | output | 32 | Value of source register B |
| aImmSum | output | 32 | Source A plus sign-extended immediate |
| done | output | 1 | One-cycle completion pulse |
| illegalErr | output | 1 | Halt caused by an illegal instruction (valid with `done`) |
| paramErr | output | 1 | Parameter count mismatch (valid with `done`) |

## Verification
The bench goes after the slot rules. A taken branch without annul must still execute its successor; a sequencer that skipped it would lose that instruction's register write, which shows up as a wrong operand in a later instruction. An annulled branch must not execute its successor; leaking it would add an extra address to the fetch trace. An exit bit placed in a delay slot must not stop the program; honouring it would end the run early. A branch placed in a delay slot must halt with the illegal flag; a design that followed it would run on to a wrong address. Writes to register 0, the preload of register 1, parameter accounting and a restart attempt while busy are each checked at the ports. Random programs built only from forward branches are compared, cycle by cycle, against an instruction-level model.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

  localparam int DATA_W = 32;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 18;

  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_BFINS  = 3'd2,
    OP_BFSHI  = 3'd3,
    OP_BFSHR  = 3'd4,
    OP_READ   = 3'd5,
    OP_BAD    = 3'd6,
    OP_BRANCH = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_BRANCH = 2'd1,
    SLOT_EXIT   = 2'd2
  } slot_e;

  typedef struct packed {
    logic              clearRegs;
    logic              regWe;
    logic              wrParam;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] srcA;
    logic [RIDX_W-1:0] srcB;
    logic [DATA_W-1:0] immExt;
  } seq_ctl_t;

  function automatic logic modeTakesParam(input logic [2:0] mode);
    return (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd5) || (mode == 3'd6);
  endfunction

  function automatic logic modeWritesParam(input logic [2:0] mode);
    return (mode == 3'd0) || (mode == 3'd3) || (mode == 3'd5);
  endfunction

endpackage

// File: rtl/macro_seq_regfile.sv
module macro_seq_regfile
  import macro_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [DATA_W-1:0] firstParam,
  input  logic [DATA_W-1:0] paramData,
  input  logic [DATA_W-1:0] execResult,
  output logic [DATA_W-1:0] srcAVal,
  output logic [DATA_W-1:0] srcBVal,
  output logic [DATA_W-1:0] aImmSum,
  output logic              aZero
);

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] wrData;

  assign wrData = ctl.wrParam ? paramData : execResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctl.clearRegs) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == 1) ? firstParam : '0;
    end else if (ctl.regWe) begin
      for (int i = 1; i < NREG; i++) begin
        if (ctl.dst == RIDX_W'(i)) regs[i] <= wrData;
      end
    end
  end

  assign srcAVal = regs[ctl.srcA];
  assign srcBVal = regs[ctl.srcB];
  assign aImmSum = srcAVal + ctl.immExt;
  assign aZero   = (srcAVal == '0);

endmodule

// File: rtl/macro_seq_ctrl.sv
module macro_seq_ctrl
  import macro_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [CNT_W-1:0]  paramCount,
  input  logic [DATA_W-1:0] instrData,
  input  logic              aZero,
  output logic [ADDR_W-1:0] instrAddr,
  output logic              busy,
  output logic [2:0]        opCode,
  output logic [2:0]        resMode,
  output logic              paramTake,
  output logic              done,
  output logic              illegalErr,
  output logic              paramErr,
  output seq_ctl_t          ctl
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e            state;
  slot_e             slot;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] jumpPc;
  logic [CNT_W-1:0]  paramIdx;

  opcode_e           op;
  logic              inSlot;
  logic              illegal;
  logic              isBranch;
  logic              taken;
  logic              annul;
  logic              exitReq;
  logic              halt;
  logic [DATA_W-1:0] immExt;
  logic [ADDR_W-1:0] target;
  logic [CNT_W-1:0]  idxNext;
  logic              unusedBit;

  assign op        = opcode_e'(instrData[2:0]);
  assign resMode   = instrData[6:4];
  assign opCode    = instrData[2:0];
  assign annul     = instrData[5];
  assign unusedBit = instrData[3];
  assign immExt    = {{(DATA_W - IMM_W){instrData[31]}}, instrData[31:14]};
  assign target    = pc + immExt[ADDR_W-1:0];

  assign busy      = (state == ST_RUN);
  assign instrAddr = pc;
  assign inSlot    = (slot != SLOT_NONE);
  assign illegal   = busy && ((op == OP_BAD) || (op == OP_BRANCH && inSlot));
  assign isBranch  = busy && !illegal && (op == OP_BRANCH);
  assign taken     = isBranch && (instrData[4] ? !aZero : aZero);
  assign exitReq   = busy && !illegal && instrData[7] && !inSlot && !taken;
  assign halt      = illegal || (busy && slot == SLOT_EXIT);
  assign paramTake = busy && !illegal && !isBranch && modeTakesParam(resMode);
  assign idxNext   = paramIdx + CNT_W'(paramTake);

  always_comb begin
    ctl.clearRegs = (state == ST_IDLE) && start;
    ctl.regWe     = busy && !illegal && !isBranch;
    ctl.wrParam   = modeWritesParam(resMode);
    ctl.dst       = instrData[10:8];
    ctl.srcA      = instrData[13:11];
    ctl.srcB      = instrData[16:14];
    ctl.immExt    = immExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      slot       <= SLOT_NONE;
      pc         <= '0;
      jumpPc     <= '0;
      paramIdx   <= '0;
      done       <= 1'b0;
      illegalErr <= 1'b0;
      paramErr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          state      <= ST_RUN;
          pc         <= startOffset;
          slot       <= SLOT_NONE;
          paramIdx   <= CNT_W'(1);
          illegalErr <= 1'b0;
          paramErr   <= 1'b0;
        end
      end else begin
        paramIdx <= idxNext;
        if (halt) begin
          state      <= ST_IDLE;
          slot       <= SLOT_NONE;
          done       <= 1'b1;
          illegalErr <= illegal;
          paramErr   <= (idxNext != paramCount);
        end else if (slot == SLOT_BRANCH) begin
          pc   <= jumpPc;
          slot <= SLOT_NONE;
        end else if (taken && annul) begin
          pc <= target;
        end else if (taken) begin
          pc     <= pc + 1'b1;
          jumpPc <= target;
          slot   <= SLOT_BRANCH;
        end else if (exitReq) begin
          pc   <= pc + 1'b1;
          slot <= SLOT_EXIT;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [CNT_W-1:0]  paramCount,
  input  logic [31:0]       firstParam,
  output logic [ADDR_W-1:0] instrAddr,
  input  logic [31:0]       instrData,
  input  logic [31:0]       paramData,
  output logic              paramTake,
  input  logic [31:0]       execResult,
  output logic              busy,
  output logic [2:0]        opCode,
  output logic [2:0]        resMode,
  output logic [31:0]       srcAVal,
  output logic [31:0]       srcBVal,
  output logic [31:0]       aImmSum,
  output logic              done,
  output logic              illegalErr,
  output logic              paramErr
);

  seq_ctl_t ctl;
  logic     aZero;

  macro_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startOffset(startOffset),
    .paramCount(paramCount), .instrData(instrData), .aZero(aZero),
    .instrAddr(instrAddr), .busy(busy), .opCode(opCode), .resMode(resMode),
    .paramTake(paramTake), .done(done), .illegalErr(illegalErr),
    .paramErr(paramErr), .ctl(ctl)
  );

  macro_seq_regfile u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .firstParam(firstParam),
    .paramData(paramData), .execResult(execResult), .srcAVal(srcAVal),
    .srcBVal(srcBVal), .aImmSum(aImmSum), .aZero(aZero)
  );

endmodule

// File: rtl/macro_seq_checks.sv
module macro_seq_checks #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] startOffset,
  input logic [ADDR_W-1:0] instrAddr,
  input logic [31:0]       instrData,
  input logic              paramTake,
  input logic              busy,
  input logic [31:0]       srcAVal,
  input logic [31:0]       aImmSum,
  input logic              done
);

  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && instrAddr == $past(startOffset)));

  a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instrData[13:11] == 3'd0) |-> (srcAVal == 32'd0));

  a_r4_take_only_running: assert property (@(posedge clk) disable iff (!rstN)
    paramTake |-> busy);

  a_r9_no_take_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instrData[2:0] == 3'd6) |-> !paramTake);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && !busy));

  a_r12_imm_sum: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (aImmSum == srcAVal + {{14{instrData[31]}}, instrData[31:14]}));

endmodule

bind macro_seq macro_seq_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rstN(rstN), .start(start), .startOffset(startOffset),
  .instrAddr(instrAddr), .instrData(instrData), .paramTake(paramTake),
  .busy(busy), .srcAVal(srcAVal), .aImmSum(aImmSum), .done(done)
);

// File: tb/macro_seq_test.sv
module macro_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 256;
  localparam int MAXTR      = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  startOffset = '0;
  logic [7:0]  paramCount = '0;
  logic [31:0] firstParam = '0;
  logic [7:0]  instrAddr;
  logic [31:0] instrData, paramData, execResult;
  logic        paramTake, busy, done, illegalErr, paramErr;
  logic [2:0]  opCode, resMode;
  logic [31:0] srcAVal, srcBVal, aImmSum;

  logic [31:0] mem [MEM_N];
  logic [31:0] prm [32];
  int          bIdx = 0;

  int testsRun = 0;
  int testsFail = 0;

  int          expLen, gotLen;
  logic        expIll, expPerr, gotIll, gotPerr;
  logic [7:0]  expAddr [MAXTR];
  logic [31:0] expA [MAXTR];
  logic [7:0]  gotAddr [MAXTR];
  logic [31:0] gotA [MAXTR];

  always #(CLK_PERIOD / 2) clk = ~clk;

  macro_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .startOffset(startOffset),
    .paramCount(paramCount), .firstParam(firstParam), .instrAddr(instrAddr),
    .instrData(instrData), .paramData(paramData), .paramTake(paramTake),
    .execResult(execResult), .busy(busy), .opCode(opCode), .resMode(resMode),
    .srcAVal(srcAVal), .srcBVal(srcBVal), .aImmSum(aImmSum), .done(done),
    .illegalErr(illegalErr), .paramErr(paramErr)
  );

  function automatic logic [31:0] sext(input logic [31:0] w);
    return {{14{w[31]}}, w[31:14]};
  endfunction

  // Stand-in for the external datapath.
  function automatic logic [31:0] extResult(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] s);
    case (op)
      3'd0:    return a + b;
      3'd1,
      3'd5:    return s;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [31:0] enc(input int op, input int mode, input int ex,
                                      input int dst, input int sa, input int imm);
    logic [31:0] w = '0;
    w[2:0]   = op[2:0];
    w[6:4]   = mode[2:0];
    w[7]     = ex[0];
    w[10:8]  = dst[2:0];
    w[13:11] = sa[2:0];
    w[31:14] = imm[17:0];
    return w;
  endfunction

  assign instrData  = mem[instrAddr];
  assign paramData  = (bIdx < 32) ? prm[bIdx] : 32'd0;
  assign execResult = extResult(opCode, srcAVal, srcBVal, aImmSum);

  always @(posedge clk) begin
    if (start && !busy) bIdx <= 1;
    else if (paramTake) bIdx <= bIdx + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Instruction-level model of the requirements.
  task automatic model(input int off, input int cnt, input logic [31:0] fp);
    logic [31:0] r [8];
    int pc, slot, jpc, idx, steps;
    logic [31:0] w, a, b, imm, res, pv;
    logic [2:0] op, mode;
    bit tk, fin;
    for (int i = 0; i < 8; i++) r[i] = '0;
    r[1] = fp; idx = 1; pc = off; slot = 0; jpc = 0;
    expLen = 0; expIll = 0; fin = 0; steps = 0;
    while (!fin && steps < MAXTR) begin
      w = mem[pc]; op = w[2:0]; mode = w[6:4];
      a = r[w[13:11]]; b = r[w[16:14]]; imm = sext(w);
      expAddr[expLen] = 8'(pc); expA[expLen] = a; expLen++; steps++;
      if (op == 3'd6 || (op == 3'd7 && slot != 0)) begin
        expIll = 1; fin = 1;
      end else begin
        tk = 0;
        if (op == 3'd7) tk = w[4] ? (a != 0) : (a == 0);
        else begin
          res = extResult(op, a, b, a + imm);
          pv = 32'd0;
          if (mode == 0 || mode == 3 || mode == 5 || mode == 6) begin
            pv = (idx < 32) ? prm[idx] : 32'd0; idx++;
          end
          if (w[10:8] != 3'd0)
            r[w[10:8]] = (mode == 0 || mode == 3 || mode == 5) ? pv : res;
        end
        if (slot == 2) fin = 1;
        else if (slot == 1) begin pc = jpc; slot = 0; end
        else if (tk && w[5]) pc = (pc + int'(imm)) & 255;
        else if (tk) begin jpc = (pc + int'(imm)) & 255; pc = (pc + 1) & 255; slot = 1; end
        else if (w[7]) begin pc = (pc + 1) & 255; slot = 2; end
        else pc = (pc + 1) & 255;
      end
    end
    expPerr = (idx != cnt);
  endtask

  task automatic run_prog(input int off, input int cnt, input logic [31:0] fp,
                          input string tag, input int intAt);
    int k = 0, cyc = 0;
    bit fin = 0;
    model(off, cnt, fp);
    @(negedge clk);
    startOffset = 8'(off); paramCount = 8'(cnt); firstParam = fp; start = 1'b1;
    @(negedge clk);
    while (!fin) begin
      start = 1'b0;
      if (busy) begin
        if (k < MAXTR) begin gotAddr[k] = instrAddr; gotA[k] = srcAVal; end
        if (k < expLen) begin
          chk(instrAddr == expAddr[k], tag, "fetch address", 32'(instrAddr), 32'(expAddr[k]));
          chk(srcAVal == expA[k], tag, "source A value", srcAVal, expA[k]);
        end
        chk(aImmSum == srcAVal + sext(mem[instrAddr]), "R12", "A plus immediate",
            aImmSum, srcAVal + sext(mem[instrAddr]));
        k++;
        if (k == intAt) begin start = 1'b1; startOffset = 8'(off + 5); end
      end else if (done) begin
        gotLen = k; gotIll = illegalErr; gotPerr = paramErr;
        chk(k == expLen, tag, "instructions executed", 32'(k), 32'(expLen));
        chk(illegalErr == expIll, "R9", "illegal flag", 32'(illegalErr), 32'(expIll));
        chk(paramErr == expPerr, "R10", "parameter flag", 32'(paramErr), 32'(expPerr));
        fin = 1;
      end
      if (cyc > 2 * MAXTR) begin
        chk(1'b0, tag, "run never finished", 32'(cyc), 32'(expLen));
        fin = 1; gotLen = k;
      end
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b0, "R10", "done lasts one cycle", 32'(done), 32'd0);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = enc(1, 1, 1, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++; testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 32; i++) prm[i] = 32'h1000_0000 + 32'(i * 17);
    fill_mem();
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "idle after reset", {30'd0, busy, done}, 32'd0);
    chk(illegalErr == 0 && paramErr == 0 && paramTake == 0, "R1", "flags after reset",
        {29'd0, illegalErr, paramErr, paramTake}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "idle after release", {30'd0, busy, done}, 32'd0);

    // Register 0 and register 1 preload; exit runs one more then halts.
    fill_mem();
    mem[10] = enc(1, 1, 0, 0, 1, 5);
    mem[11] = enc(1, 1, 0, 2, 0, 0);
    mem[12] = enc(1, 1, 1, 3, 1, 0);
    mem[13] = enc(1, 1, 0, 4, 3, 0);
    run_prog(10, 1, 32'h0000_1234, "R2", -1);
    chk(gotAddr[0] == 8'd10, "R2", "first address", 32'(gotAddr[0]), 32'd10);
    chk(gotA[0] == 32'h1234, "R2", "register 1 preload", gotA[0], 32'h1234);
    chk(gotA[1] == 32'd0, "R3", "register 0 after write", gotA[1], 32'd0);
    chk(gotLen == 4 && gotA[3] == 32'h1234, "R8", "exit trailing instruction",
        32'(gotLen), 32'd4);

    // Restart attempt while busy.
    run_prog(10, 1, 32'h0000_1234, "R11", 1);
    chk(gotLen == 4 && gotAddr[1] == 8'd11, "R11", "start during run ignored",
        32'(gotLen), 32'd4);

    // Taken branch with delay slot.
    fill_mem();
    mem[0] = enc(7, 0, 0, 0, 0, 3);
    mem[1] = enc(1, 1, 0, 2, 0, 7);
    mem[2] = enc(1, 1, 0, 3, 0, 9);
    mem[3] = enc(1, 1, 1, 4, 2, 0);
    mem[4] = enc(1, 1, 0, 5, 0, 0);
    run_prog(0, 1, 32'd5, "R6", -1);
    chk(gotLen == 4 && gotAddr[1] == 8'd1 && gotAddr[2] == 8'd3, "R6", "delay slot then target",
        32'(gotAddr[2]), 32'd3);
    chk(gotA[2] == 32'd7, "R6", "delay slot write kept", gotA[2], 32'd7);

    // Annulled branch.
    mem[0] = enc(7, 2, 0, 0, 0, 3);
    run_prog(0, 1, 32'd5, "R7", -1);
    chk(gotLen == 3 && gotAddr[1] == 8'd3, "R7", "annul skips slot", 32'(gotAddr[1]), 32'd3);
    chk(gotA[1] == 32'd0, "R7", "slot write absent", gotA[1], 32'd0);

    // Branch not taken (non-zero test on register 0).
    mem[0] = enc(7, 1, 0, 0, 0, 3);
    run_prog(0, 1, 32'd5, "R5", -1);
    chk(gotLen == 5 && gotAddr[2] == 8'd2, "R5", "fall through", 32'(gotLen), 32'd5);

    // Branch inside a delay slot.
    fill_mem();
    mem[20] = enc(7, 0, 0, 0, 0, 3);
    mem[21] = enc(7, 0, 0, 0, 0, 2);
    run_prog(20, 1, 32'd1, "R9", -1);
    chk(gotIll == 1 && gotLen == 2, "R9", "branch in slot halts", 32'(gotIll), 32'd1);

    // Parameter fetch then opcode 6.
    fill_mem();
    prm[1] = 32'h0000_BEEF;
    mem[30] = enc(1, 0, 0, 2, 0, 0);
    mem[31] = enc(1, 1, 0, 3, 2, 0);
    mem[32] = enc(6, 0, 0, 4, 0, 0);
    run_prog(30, 2, 32'd1, "R4", -1);
    chk(gotA[1] == 32'h0000_BEEF, "R4", "fetched parameter written", gotA[1], 32'h0000_BEEF);
    chk(gotIll == 1 && gotPerr == 0, "R9", "opcode 6 halts, no fetch", {30'd0, gotIll, gotPerr},
        32'd2);

    // Exit bit in a delay slot is ignored.
    fill_mem();
    mem[40] = enc(7, 0, 0, 0, 0, 3);
    mem[41] = enc(1, 1, 1, 2, 0, 1);
    mem[42] = enc(1, 1, 0, 3, 0, 0);
    mem[43] = enc(1, 1, 1, 4, 2, 0);
    mem[44] = enc(1, 1, 0, 5, 0, 0);
    run_prog(40, 1, 32'd1, "R8", -1);
    chk(gotLen == 4 && gotAddr[3] == 8'd44, "R8", "exit in slot ignored", 32'(gotLen), 32'd4);

    // Parameter accounting.
    fill_mem();
    mem[50] = enc(1, 0, 0, 2, 0, 0);
    mem[51] = enc(1, 1, 1, 3, 2, 0);
    mem[52] = enc(1, 3, 0, 4, 0, 0);
    run_prog(50, 3, 32'd1, "R10", -1);
    chk(gotPerr == 0, "R10", "count matched", 32'(gotPerr), 32'd0);
    run_prog(50, 4, 32'd1, "R10", -1);
    chk(gotPerr == 1, "R10", "count short", 32'(gotPerr), 32'd1);

    // Random programs with forward branches only.
    for (int t = 0; t < 40; t++) begin
      int off, len, cnt;
      int ops [5] = '{0, 1, 2, 5, 7};
      fill_mem();
      len = 14;
      off = int'($urandom % 200);
      cnt = 1 + int'($urandom % 6);
      for (int i = 0; i < 32; i++) prm[i] = $urandom;
      for (int i = 0; i < len - 2; i++) begin
        int op = ops[$urandom % 5];
        int ex = (($urandom % 8) == 0) ? 1 : 0;
        if (op == 7) begin
          int imm = 1 + int'($urandom % (len - 2 - i));
          mem[off + i] = enc(7, int'($urandom % 4), ex, 0, int'($urandom % 8), imm);
        end else begin
          mem[off + i] = enc(op, int'($urandom % 8), ex, int'($urandom % 8),
                             int'($urandom % 8), int'($urandom % 262144));
        end
      end
      mem[off + len - 2] = enc(1, 1, 1, 1, 2, 3);
      mem[off + len - 1] = enc(1, 1, 0, 3, 1, 1);
      run_prog(off, cnt, $urandom, "R5", (t % 5 == 0) ? 2 : -1);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule